// File: doc/BRIEF.md
# X-Masking Signature Compactor

This block sits between the scan outputs of a circuit under test and a multiple-input signature register (MISR). Each beat of the response vector comes with the pattern number, the bit (shift) number and the state of the pattern-generator LFSR that produced it. A small programmable mask table turns those three values into one mask bit per output. Each response line is ORed with its mask bit, so a masked line reaches the signature register as a constant 1 whatever the circuit drove. Positions that may carry unknown values are loaded into the table so that they cannot corrupt the signature. A separate per-pattern flag masks every output on every shift cycle of a pattern that adds no detections.

A run is opened with a `start` pulse. The signature is then cleared and responses are accepted on a valid/ready stream. `resp_ready` is high only while a run is open and its final beat has not yet been taken. A beat is consumed on a cycle with both `resp_valid` and `resp_ready` high. While `resp_valid` is low the producer may stall for any number of cycles, and the signature holds. The beat tagged with the last pattern and the last bit number closes the run. Once that beat has been folded in, `done` rises and the signature stays frozen until the next `start`.

Mask lookup and the response are registered together, so both reach the OR stage in the same cycle. The MISR absorbs that registered word on the following edge.

Top module: `xmc_compactor`

## Requirements
- R1: After reset `signature` is 0, `done` is 0 and `resp_ready` is 0.
- R2: A `start` pulse taken while idle or done clears `signature` to 0, drops `done` and raises `resp_ready` on the next cycle.
- R3: With no mask active, an accepted beat with response `d` updates the signature `s` to `{s[W-2:0],0} ^ (s[W-1] ? POLY : 0) ^ d`, with the default POLY = 8'h1D. The result is visible after the second clock edge that follows acceptance.
- R4: A valid table entry whose pattern and bit fields equal the beat's counters, and whose LFSR compare passes, forces its output-mask bits to 1 before compaction. Masks from several matching entries combine by OR.
- R5: An entry's LFSR compare passes only when `(lfsr_state & care) == (value & care)`. A beat whose state fails the compare is not masked by that entry.
- R6: When the mask-all flag of pattern P is set, every output of every beat tagged with pattern P enters the MISR as 1.
- R7: The values driven on masked output positions have no effect on the signature.
- R8: Beats are consumed only when `resp_valid` and `resp_ready` are both high. While no beat is consumed, the signature does not change.
- R9: When the beat with pattern NUM_PAT-1 and bit NUM_BITS-1 is taken, `resp_ready` falls on the next cycle. After that beat has been absorbed, `done` is 1 and `signature` stays frozen until the next `start`.
- R10: A `start` pulse during an open run is ignored. The signature is not cleared and `resp_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Opens a run and clears the signature |
| resp_valid | input | 1 | Response beat valid |
| resp_ready | output | 1 | Block can take a beat |
| resp_data | input | NOUT | Response vector from the scan outputs |
| pat_cnt | input | PAT_W | Pattern number of this beat |
| bit_cnt | input | BIT_W | Shift number of this beat |
| lfsr_state | input | LFSR_W | Generator LFSR state for this beat |
| tbl_wr | input | 1 | Write one mask table entry |
| tbl_sel | input | SEL_W | Entry index to write |
| tbl_vld | input | 1 | Entry enable |
| tbl_pat | input | PAT_W | Entry pattern match value |
| tbl_bit | input | BIT_W | Entry shift match value |
| tbl_lcare | input | LFSR_W | LFSR bits taking part in the compare |
| tbl_lval | input | LFSR_W | LFSR compare value |
| tbl_omask | input | NOUT | Outputs forced to 1 on a match |
| all_wr | input | 1 | Write one per-pattern mask-all flag |
| all_pat | input | PAT_W | Pattern whose flag is written |
| all_set | input | 1 | Flag value |
| done | output | 1 | Run complete, signature final |
| signature | output | NOUT | MISR contents |

## Verification
An accepted beat is registered with its mask on the first edge and folded into the MISR on the second. The bench therefore drives each beat for one edge, holds `resp_valid` low through the next edge, and compares `signature` against its own model at the negative edge after that. `resp_ready` and `done` move one edge after the final beat and one edge later respectively, so both are sampled once the final beat's two edges have passed. A `start` takes effect on the next edge, and the cleared signature and raised ready are checked half a cycle later. Stall, freeze and ignored-start cases are checked for an unchanged signature at the same sampling points.

// File: rtl/xmc_pkg.sv
package xmc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DONE  = 2'd3
  } run_st_e;

endpackage

// File: rtl/xmc_mask_table.sv
module xmc_mask_table #(
  parameter int NOUT    = 8,
  parameter int PAT_W   = 4,
  parameter int BIT_W   = 4,
  parameter int LFSR_W  = 8,
  parameter int ENTRIES = 4,
  localparam int SEL_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int NALL   = 1 << PAT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic              e_vld,
  input  logic [PAT_W-1:0]  e_pat,
  input  logic [BIT_W-1:0]  e_bit,
  input  logic [LFSR_W-1:0] e_lcare,
  input  logic [LFSR_W-1:0] e_lval,
  input  logic [NOUT-1:0]   e_omask,
  input  logic              all_wr,
  input  logic [PAT_W-1:0]  all_pat,
  input  logic              all_set,
  input  logic [PAT_W-1:0]  look_pat,
  input  logic [BIT_W-1:0]  look_bit,
  input  logic [LFSR_W-1:0] look_lfsr,
  output logic [NOUT-1:0]   mask,
  output logic              all_hit
);

  logic              ent_vld   [ENTRIES];
  logic [PAT_W-1:0]  ent_pat   [ENTRIES];
  logic [BIT_W-1:0]  ent_bit   [ENTRIES];
  logic [LFSR_W-1:0] ent_lcare [ENTRIES];
  logic [LFSR_W-1:0] ent_lval  [ENTRIES];
  logic [NOUT-1:0]   ent_omask [ENTRIES];
  logic [NALL-1:0]   all_flags;
  logic [NOUT-1:0]   hit_mask  [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[g]   <= 1'b0;
        ent_pat[g]   <= '0;
        ent_bit[g]   <= '0;
        ent_lcare[g] <= '0;
        ent_lval[g]  <= '0;
        ent_omask[g] <= '0;
      end else if (wr && (sel == SEL_W'(g))) begin
        ent_vld[g]   <= e_vld;
        ent_pat[g]   <= e_pat;
        ent_bit[g]   <= e_bit;
        ent_lcare[g] <= e_lcare;
        ent_lval[g]  <= e_lval;
        ent_omask[g] <= e_omask;
      end
    end

    logic state_ok;
    logic match;
    assign state_ok    = ((look_lfsr ^ ent_lval[g]) & ent_lcare[g]) == '0;
    assign match       = ent_vld[g] && (ent_pat[g] == look_pat) &&
                         (ent_bit[g] == look_bit) && state_ok;
    assign hit_mask[g] = match ? ent_omask[g] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      all_flags <= '0;
    end else if (all_wr) begin
      all_flags[all_pat] <= all_set;
    end
  end

  always_comb begin
    logic [NOUT-1:0] acc;
    acc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      acc = acc | hit_mask[i];
    end
    all_hit = all_flags[look_pat];
    mask    = all_hit ? '1 : acc;
  end

endmodule

// File: rtl/xmc_misr.sv
module xmc_misr #(
  parameter int             W    = 8,
  parameter logic [W-1:0]   POLY = 8'h1D
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] sig
);

  logic [W-1:0] fb;
  logic [W-1:0] nxt;

  assign fb  = sig[W-1] ? POLY : '0;
  assign nxt = {sig[W-2:0], 1'b0} ^ fb ^ din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig <= '0;
    end else if (clear) begin
      sig <= '0;
    end else if (load) begin
      sig <= nxt;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (sig == '0)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !load) |=> $stable(sig)); // R8

endmodule

// File: rtl/xmc_run_ctrl.sv
module xmc_run_ctrl
  import xmc_pkg::*;
#(
  parameter int PAT_W    = 4,
  parameter int BIT_W    = 4,
  parameter int NUM_PAT  = 4,
  parameter int NUM_BITS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             take,
  input  logic [PAT_W-1:0] pat,
  input  logic [BIT_W-1:0] bitn,
  output logic             ready,
  output logic             clear,
  output logic             last_take,
  output logic             done
);

  localparam logic [PAT_W-1:0] LAST_PAT = PAT_W'(NUM_PAT - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NUM_BITS - 1);

  run_st_e st;
  run_st_e st_nxt;

  assign clear     = start && ((st == ST_IDLE) || (st == ST_DONE));
  assign last_take = take && (pat == LAST_PAT) && (bitn == LAST_BIT);
  assign ready     = (st == ST_RUN);
  assign done      = (st == ST_DONE);

  always_comb begin
    st_nxt = st;
    unique case (st)
      ST_IDLE:  if (clear) st_nxt = ST_RUN;
      ST_RUN:   if (last_take) st_nxt = ST_DRAIN;
      ST_DRAIN: st_nxt = ST_DONE;
      ST_DONE:  if (clear) st_nxt = ST_RUN;
      default:  st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= st_nxt;
  end

  AST_DONE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !ready); // R9

  AST_LAST_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> !ready); // R9

  AST_START_IGNORED_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && start && !last_take) |=> ready); // R10

endmodule

// File: rtl/xmc_compactor.sv
module xmc_compactor #(
  parameter int               NOUT     = 8,
  parameter int               PAT_W    = 4,
  parameter int               BIT_W    = 4,
  parameter int               LFSR_W   = 8,
  parameter int               ENTRIES  = 4,
  parameter int               NUM_PAT  = 4,
  parameter int               NUM_BITS = 4,
  parameter logic [NOUT-1:0]  POLY     = 8'h1D,
  localparam int              SEL_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              resp_valid,
  output logic              resp_ready,
  input  logic [NOUT-1:0]   resp_data,
  input  logic [PAT_W-1:0]  pat_cnt,
  input  logic [BIT_W-1:0]  bit_cnt,
  input  logic [LFSR_W-1:0] lfsr_state,
  input  logic              tbl_wr,
  input  logic [SEL_W-1:0]  tbl_sel,
  input  logic              tbl_vld,
  input  logic [PAT_W-1:0]  tbl_pat,
  input  logic [BIT_W-1:0]  tbl_bit,
  input  logic [LFSR_W-1:0] tbl_lcare,
  input  logic [LFSR_W-1:0] tbl_lval,
  input  logic [NOUT-1:0]   tbl_omask,
  input  logic              all_wr,
  input  logic [PAT_W-1:0]  all_pat,
  input  logic              all_set,
  output logic              done,
  output logic [NOUT-1:0]   signature
);

  logic            take;
  logic            clear;
  logic            last_take;
  logic [NOUT-1:0] mask;
  logic            all_hit;
  logic            s1_vld;
  logic [NOUT-1:0] s1_data;

  assign take = resp_valid && resp_ready;

  xmc_run_ctrl #(
    .PAT_W(PAT_W), .BIT_W(BIT_W), .NUM_PAT(NUM_PAT), .NUM_BITS(NUM_BITS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .take(take),
    .pat(pat_cnt), .bitn(bit_cnt),
    .ready(resp_ready), .clear(clear), .last_take(last_take), .done(done)
  );

  xmc_mask_table #(
    .NOUT(NOUT), .PAT_W(PAT_W), .BIT_W(BIT_W), .LFSR_W(LFSR_W), .ENTRIES(ENTRIES)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr(tbl_wr), .sel(tbl_sel), .e_vld(tbl_vld), .e_pat(tbl_pat),
    .e_bit(tbl_bit), .e_lcare(tbl_lcare), .e_lval(tbl_lval), .e_omask(tbl_omask),
    .all_wr(all_wr), .all_pat(all_pat), .all_set(all_set),
    .look_pat(pat_cnt), .look_bit(bit_cnt), .look_lfsr(lfsr_state),
    .mask(mask), .all_hit(all_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld  <= 1'b0;
      s1_data <= '0;
    end else begin
      s1_vld <= take;
      if (take) s1_data <= resp_data | mask;
    end
  end

  xmc_misr #(.W(NOUT), .POLY(POLY)) u_misr (
    .clk(clk), .rst_n(rst_n), .clear(clear), .load(s1_vld),
    .din(s1_data), .sig(signature)
  );

  AST_MASK_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && all_hit) |=> (s1_data == '1)); // R6

  AST_PASS_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (mask == '0)) |=> (s1_data == $past(resp_data))); // R3

  AST_SIG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> $stable(signature)); // R9

  AST_LAST_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    last_take |=> ##1 done); // R9

endmodule

// File: tb/xmc_compactor_test.sv
module xmc_compactor_test;

  localparam int NOUT = 8;
  localparam int NB   = 16;

  // Each vector: {response[15:8], lfsr_state[7:0]}; beat k has pattern k/4, bit k%4
  localparam logic [15:0] VEC [NB] = '{
    16'hA5_11, 16'h3C_22, 16'h96_33, 16'h01_44,
    16'h7E_55, 16'hC3_66, 16'h5A_77, 16'h18_88,
    16'hE7_99, 16'h24_0D, 16'h81_BB, 16'h6F_CC,
    16'h00_DD, 16'h42_EE, 16'h99_FF, 16'h13_10
  };

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic resp_valid = 0;
  logic resp_ready;
  logic [7:0] resp_data = '0;
  logic [3:0] pat_cnt = '0;
  logic [3:0] bit_cnt = '0;
  logic [7:0] lfsr_state = '0;
  logic tbl_wr = 0;
  logic [1:0] tbl_sel = '0;
  logic tbl_vld = 0;
  logic [3:0] tbl_pat = '0;
  logic [3:0] tbl_bit = '0;
  logic [7:0] tbl_lcare = '0;
  logic [7:0] tbl_lval = '0;
  logic [7:0] tbl_omask = '0;
  logic all_wr = 0;
  logic [3:0] all_pat = '0;
  logic all_set = 0;
  logic done;
  logic [7:0] signature;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic [7:0] exp_sig;
  logic [7:0] sig_a;

  always #5 clk = ~clk;

  xmc_compactor uut (
    .clk(clk), .rst_n(rst_n), .start(start), .resp_valid(resp_valid),
    .resp_ready(resp_ready), .resp_data(resp_data), .pat_cnt(pat_cnt),
    .bit_cnt(bit_cnt), .lfsr_state(lfsr_state), .tbl_wr(tbl_wr),
    .tbl_sel(tbl_sel), .tbl_vld(tbl_vld), .tbl_pat(tbl_pat), .tbl_bit(tbl_bit),
    .tbl_lcare(tbl_lcare), .tbl_lval(tbl_lval), .tbl_omask(tbl_omask),
    .all_wr(all_wr), .all_pat(all_pat), .all_set(all_set), .done(done),
    .signature(signature)
  );

  function automatic logic [7:0] misr_step(logic [7:0] s, logic [7:0] d);
    return {s[6:0], 1'b0} ^ (s[7] ? 8'h1D : 8'h00) ^ d;
  endfunction

  // Mask expected from the table contents the bench loads below
  function automatic logic [7:0] mask_of(int pat, int bn, logic [7:0] lf);
    logic [7:0] m;
    m = 8'h00;
    if (pat == 3) return 8'hFF;
    if (pat == 1 && bn == 2) m = m | 8'h0F;
    if (pat == 2 && bn == 1 && lf[1:0] == 2'b01) m = m | 8'hF0;
    if (pat == 2 && bn == 1) m = m | 8'h01;
    return m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_entry(int idx, int p, int b, logic [7:0] care,
                            logic [7:0] val, logic [7:0] om);
    @(negedge clk);
    tbl_wr = 1; tbl_sel = 2'(idx); tbl_vld = 1; tbl_pat = 4'(p);
    tbl_bit = 4'(b); tbl_lcare = care; tbl_lval = val; tbl_omask = om;
    @(negedge clk);
    tbl_wr = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1;
    @(negedge clk);
    start = 0;
  endtask

  // Drive one beat for a single edge, then leave two edges for the MISR
  task automatic send_beat(int k, logic [7:0] resp, logic [7:0] lf);
    @(negedge clk);
    resp_valid = 1; resp_data = resp; pat_cnt = 4'(k / 4);
    bit_cnt = 4'(k % 4); lfsr_state = lf;
    @(negedge clk);
    resp_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=finish", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 signature", signature, 8'h00);
    check("R1 done", done, 0);
    check("R1 ready", resp_ready, 0);
    rst_n = 1;

    load_entry(0, 1, 2, 8'h00, 8'h00, 8'h0F);
    load_entry(1, 2, 1, 8'h03, 8'h01, 8'hF0);
    load_entry(2, 2, 1, 8'h00, 8'h00, 8'h01);
    @(negedge clk);
    all_wr = 1; all_pat = 4'd3; all_set = 1;
    @(negedge clk);
    all_wr = 0;

    // Run A: table-driven vectors
    pulse_start();
    check("R2 ready after start", resp_ready, 1);
    check("R2 cleared", signature, 8'h00);
    exp_sig = 8'h00;
    for (int k = 0; k < NB; k++) begin
      logic [7:0] r;
      logic [7:0] lf;
      r  = VEC[k][15:8];
      lf = VEC[k][7:0];
      send_beat(k, r, lf);
      exp_sig = misr_step(exp_sig, r | mask_of(k / 4, k % 4, lf));
      // R3 plain beats, R4 entry hits (k=6, k=9), R5 compare pass (k=9), R6 mask-all (k>=12)
      check((k >= 12) ? "R6 mask-all beat" : ((k == 6 || k == 9) ? "R4 entry hit" : "R3 beat"),
            signature, exp_sig);
    end
    check("R9 done", done, 1);
    check("R9 ready low", resp_ready, 0);
    sig_a = signature;

    // Freeze after done: a valid beat must not be consumed
    @(negedge clk);
    resp_valid = 1; resp_data = 8'h5C; pat_cnt = 0; bit_cnt = 0;
    repeat (3) @(negedge clk);
    resp_valid = 0;
    @(negedge clk);
    check("R9 frozen", signature, sig_a);
    check("R8 no take when not ready", done, 1);

    // Run B: masked positions carry different values
    pulse_start();
    check("R2 restart clears", signature, 8'h00);
    check("R2 done dropped", done, 0);
    for (int k = 0; k < NB; k++) begin
      logic [7:0] lf;
      lf = VEC[k][7:0];
      send_beat(k, VEC[k][15:8] ^ mask_of(k / 4, k % 4, lf), lf);
    end
    check("R7 masked values ignored", signature, sig_a);

    // Run C: LFSR compare failure, stall, start during run
    pulse_start();
    exp_sig = 8'h00;
    for (int k = 0; k < NB; k++) begin
      logic [7:0] r;
      logic [7:0] lf;
      r  = VEC[k][15:8];
      lf = (k == 9) ? 8'h02 : VEC[k][7:0];
      send_beat(k, r, lf);
      exp_sig = misr_step(exp_sig, r | mask_of(k / 4, k % 4, lf));
      if (k == 9) check("R5 compare fail not masked", signature, exp_sig);
      if (k == 3) begin
        repeat (4) @(negedge clk);
        check("R8 stall holds", signature, exp_sig);
        pulse_start();
        check("R10 start ignored sig", signature, exp_sig);
        check("R10 start ignored ready", resp_ready, 1);
      end
    end
    check("R9 done run C", done, 1);
    check("R3 final run C", signature, exp_sig);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule